// File: doc/BRIEF.md
# Consecutive-Frame Persistency Filter

This block debounces one monitored overhead field on a per-frame basis. Once per frame a strobe presents the field's value and a flag that tells whether that frame's framing pattern was received cleanly. The block publishes a new value as the accepted value only after that value has arrived unchanged for N consecutive clean frames. N is a 4-bit programmable threshold.

Every accepted update raises a one-cycle change pulse and a sticky delta flag. Software clears the delta flag with a write-one-to-clear strobe. A mask bit gates the delta flag onto an interrupt output. Generating the frame strobe and detecting framing errors are handled by logic outside this block.

Top module: `frame_persist_filter`

## Requirements
- R1: The accepted value changes only in the cycle after a frame strobe whose frame is free of framing errors. Between strobes it holds, whatever the field input does.
- R2: With threshold N, a value that differs from the accepted value becomes the accepted value in the cycle after the Nth consecutive clean frame that carries it. It does not change after the (N-1)th such frame.
- R3: A frame flagged with a framing error clears the run count to zero and never updates the accepted value. The next clean frame starts a new run at one.
- R4: A clean frame whose value differs from the previous frame's value restarts the run at one with the new value.
- R5: A threshold of 0 behaves exactly like a threshold of 1, so a single clean frame with a new value is accepted.
- R6: A clean frame carrying the value that is already accepted produces no update and no change pulse.
- R7: The change pulse is high for exactly one cycle, in the same cycle the new accepted value first appears.
- R8: An update sets the delta flag, which then stays set until a clear strobe is given. If an update and a clear strobe occur in the same cycle, the flag stays set.
- R9: The interrupt output equals the delta flag AND NOT the mask input.
- R10: After reset the accepted value is 0, the run count is 0, and the change pulse, delta flag and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe, once per frame |
| field_in | input | W | Monitored field value for this frame |
| frame_err | input | 1 | Framing error seen in this frame |
| thresh | input | TW | Consecutive-frame threshold N (0 acts as 1) |
| irq_mask | input | 1 | 1 blocks the delta flag from the interrupt |
| delta_clr | input | 1 | Write-one-to-clear strobe for the delta flag |
| acc_value | output | W | Accepted (filtered) value |
| chg_pulse | output | 1 | One-cycle pulse on each update |
| delta | output | 1 | Sticky update flag |
| irq | output | 1 | Masked interrupt |

## Verification
The embedded assertions check several properties on every cycle:
- the accepted value stays stable between strobes and across errored frames;
- an errored frame clears the run count;
- every change pulse coincides with a real change of the accepted value;
- the delta flag stays set until it is cleared;
- the interrupt agrees with the flag and the mask.

Other behaviours only the bench scenarios can show, because each depends on a sequence of frames:
- acceptance happening at exactly the Nth clean frame and not earlier;
- a run restarting after a value change or an error;
- a threshold of 0 acting as 1;
- the longest threshold of 15;
- an update winning over a clear strobe in the same cycle.

// File: rtl/frame_persist_filter.sv
module frame_persist_filter #(
  parameter int W  = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic [W-1:0]  field_in,
  input  logic          frame_err,
  input  logic [TW-1:0] thresh,
  input  logic          irq_mask,
  input  logic          delta_clr,
  output logic [W-1:0]  acc_value,
  output logic          chg_pulse,
  output logic          delta,
  output logic          irq
);

  logic [W-1:0]  cand_q, acc_q;
  logic [TW-1:0] cnt_q;
  logic          pulse_q, delta_q;

  wire [TW-1:0] n_eff    = (thresh == '0) ? TW'(1) : thresh;
  wire          same_acc = (field_in == acc_q);
  wire          restart  = (field_in != cand_q) || (cnt_q == '0);
  wire [TW:0]   run_len  = restart ? (TW+1)'(1) : ({1'b0, cnt_q} + (TW+1)'(1));
  wire          accept   = frame_tick && !frame_err && !same_acc &&
                           (run_len >= {1'b0, n_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      delta_q <= 1'b0;
    end else begin
      pulse_q <= accept;
      if (accept)         delta_q <= 1'b1;
      else if (delta_clr) delta_q <= 1'b0;
      if (frame_tick) begin
        cand_q <= field_in;
        if (frame_err) begin
          cnt_q <= '0;
        end else if (same_acc) begin
          cnt_q <= cnt_q;
        end else if (accept) begin
          acc_q <= field_in;
          cnt_q <= '0;
        end else begin
          cnt_q <= run_len[TW-1:0];
        end
      end
    end
  end

  assign acc_value = acc_q;
  assign chg_pulse = pulse_q;
  assign delta     = delta_q;
  assign irq       = delta_q & ~irq_mask;

  AST_ACC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(acc_value)); // R1
  AST_ERR_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && frame_err) |=> (cnt_q == '0) && $stable(acc_value)); // R3
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse |-> (acc_value != $past(acc_value))); // R7
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_value != $past(acc_value)) |-> chg_pulse); // R7
  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && !delta_clr) |=> delta); // R8
  AST_PULSE_SETS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse |-> delta); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (delta && !irq_mask)); // R9

endmodule

// File: tb/frame_persist_filter_bench.sv
module frame_persist_filter_bench;
  localparam int W = 8;
  localparam int TW = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic frame_tick = 0, frame_err = 0, irq_mask = 1, delta_clr = 0;
  logic [W-1:0] field_in = '0;
  logic [TW-1:0] thresh = 4'd3;
  logic [W-1:0] acc_value;
  logic chg_pulse, delta, irq;

  int errors = 0, checks = 0;
  logic [W:0] q_exp[$];
  string      q_tag[$];

  logic [W-1:0] m_acc = '0, m_cand = '0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_persist_filter #(.W(W), .TW(TW)) u_frame_persist_filter (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .field_in(field_in),
    .frame_err(frame_err), .thresh(thresh), .irq_mask(irq_mask),
    .delta_clr(delta_clr), .acc_value(acc_value), .chg_pulse(chg_pulse),
    .delta(delta), .irq(irq));

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one frame, model predicts {pulse, acc} and queues it for the monitor
  task automatic frame(input logic [W-1:0] v, input logic err, input string tag,
                       input logic clr = 1'b0);
    int n;
    logic pulse;
    n = (thresh == 0) ? 1 : int'(thresh);
    pulse = 1'b0;
    @(negedge clk);
    frame_tick = 1; field_in = v; frame_err = err; delta_clr = clr;
    if (err) m_cnt = 0;
    else if (v != m_acc) begin
      if (v != m_cand || m_cnt == 0) m_cnt = 1; else m_cnt++;
      if (m_cnt >= n) begin m_acc = v; m_cnt = 0; pulse = 1'b1; end
    end
    m_cand = v;
    @(posedge clk);
    q_exp.push_back({pulse, m_acc});
    q_tag.push_back(tag);
    @(negedge clk);
    frame_tick = 0; frame_err = 0; delta_clr = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      chk(q_tag.pop_front(), {chg_pulse, acc_value}, q_exp.pop_front());
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 reset", {chg_pulse, acc_value}, '0);
    chk("R10 reset flags", {7'd0, delta, irq}, '0);
    rst_n = 1;
    idle(2);

    // R2: N=3
    thresh = 4'd3;
    frame(8'h05, 0, "R2 frame1");
    frame(8'h05, 0, "R2 frame2");
    frame(8'h05, 0, "R2 frame3 accept");
    @(negedge clk);
    chk("R7 pulse one cycle", {8'd0, chg_pulse}, '0);
    chk("R8 delta set", {8'd0, delta}, 9'd1);
    chk("R9 masked irq", {8'd0, irq}, '0);
    irq_mask = 0; #1;
    chk("R9 unmasked irq", {8'd0, irq}, 9'd1);

    // R1: field moves without strobes
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); field_in = 8'(8'hA0 + i);
    end
    @(negedge clk);
    chk("R1 hold between strobes", {1'b0, acc_value}, {1'b0, 8'h05});

    // R8: clear
    @(negedge clk); delta_clr = 1;
    @(negedge clk); delta_clr = 0;
    chk("R8 delta cleared", {7'd0, delta, irq}, '0);

    // R3: error mid run
    frame(8'h07, 0, "R3 f1");
    frame(8'h07, 0, "R3 f2");
    frame(8'h07, 1, "R3 errored frame");
    frame(8'h07, 0, "R3 restart 1");
    frame(8'h07, 0, "R3 restart 2");
    frame(8'h07, 0, "R3 accept after 3 clean");

    // R4: value change restarts run
    frame(8'h09, 0, "R4 f1");
    frame(8'h09, 0, "R4 f2");
    frame(8'h04, 0, "R4 change restarts");
    frame(8'h04, 0, "R4 run 2");
    frame(8'h04, 0, "R4 accept");

    // R5: threshold zero
    thresh = 4'd0;
    frame(8'h22, 0, "R5 zero acts as one");
    // R6: same as accepted
    thresh = 4'd1;
    frame(8'h22, 0, "R6 same value no update");
    frame(8'h22, 1, "R3 error N=1 no update");

    // R8: set wins over clear
    @(negedge clk); delta_clr = 1;
    @(negedge clk); delta_clr = 0;
    frame(8'h33, 0, "R8 accept with clear", 1'b1);
    chk("R8 set wins over clear", {8'd0, delta}, 9'd1);

    // R2: longest threshold
    thresh = 4'd15;
    for (int i = 0; i < 15; i++) frame(8'h5A, 0, "R2 N=15 run");
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule